// File: doc/BRIEF.md
# Majority-Clocked Three-Register Keystream Generator

This block produces a bit-serial keystream from three linear feedback shift registers of 19, 22 and 23 bits. Outside its setup phases the registers step irregularly: in each cycle the three clocking bits are put to a majority vote, and only the registers whose clocking bit matches that vote advance. So two or three of the registers step on every cycle.

The block starts on a single-cycle start pulse. That pulse captures a 64-bit key and a 22-bit frame number. The block then runs four phases, one register step per cycle:

- **Key injection:** every register steps on each of 64 cycles, with one key bit folded into bit 0 after each step.
- **Frame injection:** the same for 22 cycles, with one frame-number bit folded in per step.
- **Mixing:** 100 silent cycles under majority clocking, with no output.
- **Output:** 228 cycles, each presenting one keystream bit with a valid strobe.

A direction flag separates the first 114 output bits from the last 114. A busy level covers the whole run. A done pulse marks the final bit. Encrypting traffic, advancing frame numbers and deriving keys are left to the surrounding logic.

Top module: `mvote_keystream`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `ks_valid_o` and `ks_dir_o` are all 0.
- R2: A register step shifts the register left by one place and writes the XOR of its feedback taps into bit 0. The taps are:
  - 19-bit register: bits 18, 17, 16 and 13.
  - 22-bit register: bits 21 and 20.
  - 23-bit register: bits 22, 21, 20 and 7.
- R3: During mixing and output, the clocking bits are bit 8 of the 19-bit register and bit 10 of each of the other two. A register steps only when its clocking bit equals the majority of the three clocking bits; otherwise it holds its value.
- R4: An accepted start clears all three registers to zero. During the 64 key cycles and the 22 frame cycles, every register steps on every cycle regardless of the vote. After each such step the injected bit is XORed into bit 0 of each register.
- R5: Key bits are injected in the order `key_i[0]`, `key_i[1]`, …, `key_i[63]`. Byte 0 of a key handed over as a byte array sits in `key_i[63:56]`, and each byte is consumed LSB first, starting from its last byte.
- R6: Frame bits are injected after the key in the order `frame_i[0]` to `frame_i[21]`.
- R7: 100 majority-clocked steps follow frame injection. `ks_valid_o` stays 0 during all of them.
- R8: Each keystream bit is the XOR of bit 18, bit 21 and bit 22 of the three registers, taken after that cycle's step.
- R9: Exactly 228 bits are presented with `ks_valid_o` high. `ks_dir_o` is 0 for bits 0 to 113 and 1 for bits 114 to 227, and it is 0 whenever `ks_valid_o` is 0.
- R10: A start pulse that arrives while `busy_o` is 1 is ignored. The running keystream is unchanged by it.
- R11: `done_o` is high for exactly one cycle, together with the 228th valid bit. In that same cycle `busy_o` is already 0.
- R12: If start is sampled at clock edge 0, the first valid bit appears after edge 187 and the last after edge 414. `busy_o` is 1 from edge 0 through edge 413.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse; captures key and frame when idle |
| key_i | input | 64 | Session key, injected from bit 0 upward |
| frame_i | input | 22 | Frame number, injected from bit 0 upward |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle pulse with the final keystream bit |
| ks_bit_o | output | 1 | Keystream bit |
| ks_valid_o | output | 1 | Keystream bit is valid |
| ks_dir_o | output | 1 | 0 for the first 114 bits, 1 for the last 114 |

## Verification
The hardest situation to reach from the ports is a second start pulse landing in the middle of a run. If it were taken, it would silently reload the registers and corrupt the rest of the keystream. The bench therefore injects conflicting start pulses during key injection, mixing and output, each carrying a different key. It then demands a keystream identical to a clean run.

Majority corner states, where all three clocking bits agree, arise only after setup. They are reached by sweeping every single-bit key and every single-bit frame number. Each of those 228-bit streams is compared against an arithmetic model kept in the bench.

// File: rtl/mvk_pkg.sv
package mvk_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_KEY   = 3'd1,
    PH_FRAME = 3'd2,
    PH_MIX   = 3'd3,
    PH_RUN   = 3'd4
  } phase_t;

  localparam int unsigned A_W = 19;
  localparam int unsigned B_W = 22;
  localparam int unsigned C_W = 23;
  localparam logic [A_W-1:0] A_TAPS = 19'h72000;
  localparam logic [B_W-1:0] B_TAPS = 22'h300000;
  localparam logic [C_W-1:0] C_TAPS = 23'h700080;
  localparam int unsigned A_CLK = 8;
  localparam int unsigned B_CLK = 10;
  localparam int unsigned C_CLK = 10;
endpackage

// File: rtl/mvk_lfsr.sv
module mvk_lfsr #(
  parameter int unsigned W = 19,
  parameter logic [W-1:0] TAPS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         fb;

  assign fb = ^(q & TAPS);

  always_comb begin
    q_d = q;
    if (clr) q_d = '0;
    else if (en) q_d = {q[W-2:0], fb ^ din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  // R3: a register not chosen to step keeps its contents
  a_r3_hold_unstepped: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(q));
  // R4: clear wins and empties the register
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
endmodule

// File: rtl/mvk_vote.sv
module mvk_vote (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       force_all,
  input  logic       vote_on,
  input  logic [2:0] ctl_bits,
  output logic [2:0] step_en
);
  logic maj;

  assign maj = (ctl_bits[0] & ctl_bits[1]) | (ctl_bits[0] & ctl_bits[2]) |
               (ctl_bits[1] & ctl_bits[2]);

  always_comb begin
    step_en = 3'b000;
    if (force_all) step_en = 3'b111;
    else if (vote_on) begin
      for (int i = 0; i < 3; i++) step_en[i] = (ctl_bits[i] == maj);
    end
  end

  // R3: under the vote at least two registers advance
  a_r3_two_or_three: assert property (@(posedge clk) disable iff (!rst_n)
    (vote_on && !force_all) |-> ($countones(step_en) >= 2));
  // R4: injection cycles step every register
  a_r4_all_step: assert property (@(posedge clk) disable iff (!rst_n)
    force_all |-> (step_en == 3'b111));
endmodule

// File: rtl/mvk_seq.sv
module mvk_seq
  import mvk_pkg::*;
#(
  parameter int unsigned KEY_BITS   = 64,
  parameter int unsigned FRAME_BITS = 22,
  parameter int unsigned MIX_STEPS  = 100,
  parameter int unsigned HALF_BITS  = 114
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_t phase,
  output logic   clr,
  output logic   inject,
  output logic   vote_on,
  output logic   emit,
  output logic   emit_dir,
  output logic   emit_last
);
  localparam int unsigned OUT_BITS = 2 * HALF_BITS;
  localparam int unsigned MAXLEN =
    (OUT_BITS > MIX_STEPS ? OUT_BITS : MIX_STEPS) > KEY_BITS ?
    (OUT_BITS > MIX_STEPS ? OUT_BITS : MIX_STEPS) : KEY_BITS;
  localparam int unsigned CNT_W = $clog2(MAXLEN + 1);

  phase_t           phase_d;
  logic [CNT_W-1:0] cnt, cnt_d;
  logic             at_end;
  logic [CNT_W-1:0] end_val;

  always_comb begin
    case (phase)
      PH_KEY:   end_val = CNT_W'(KEY_BITS - 1);
      PH_FRAME: end_val = CNT_W'(FRAME_BITS - 1);
      PH_MIX:   end_val = CNT_W'(MIX_STEPS - 1);
      default:  end_val = CNT_W'(OUT_BITS - 1);
    endcase
  end

  assign at_end    = (cnt == end_val);
  assign clr       = (phase == PH_IDLE) && start;
  assign inject    = (phase == PH_KEY) || (phase == PH_FRAME);
  assign vote_on   = (phase == PH_MIX) || (phase == PH_RUN);
  assign emit      = (phase == PH_RUN);
  assign emit_dir  = emit && (cnt >= CNT_W'(HALF_BITS));
  assign emit_last = emit && at_end;

  always_comb begin
    phase_d = phase;
    cnt_d   = cnt;
    case (phase)
      PH_IDLE: if (start) begin phase_d = PH_KEY; cnt_d = '0; end
      PH_KEY:   if (at_end) begin phase_d = PH_FRAME; cnt_d = '0; end else cnt_d = cnt + 1'b1;
      PH_FRAME: if (at_end) begin phase_d = PH_MIX;   cnt_d = '0; end else cnt_d = cnt + 1'b1;
      PH_MIX:   if (at_end) begin phase_d = PH_RUN;   cnt_d = '0; end else cnt_d = cnt + 1'b1;
      PH_RUN:   if (at_end) begin phase_d = PH_IDLE;  cnt_d = '0; end else cnt_d = cnt + 1'b1;
      default: begin phase_d = PH_IDLE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phase_d;
      cnt   <= cnt_d;
    end
  end

  // R10: a run in progress is never cut short by another start
  a_r10_run_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !(emit_last)) |=> (phase != PH_IDLE));
  // R7: mixing always follows frame injection
  a_r7_frame_to_mix: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FRAME && at_end) |=> (phase == PH_MIX));
endmodule

// File: rtl/mvote_keystream.sv
module mvote_keystream
  import mvk_pkg::*;
#(
  parameter int unsigned KEY_BITS   = 64,
  parameter int unsigned FRAME_BITS = 22,
  parameter int unsigned MIX_STEPS  = 100,
  parameter int unsigned HALF_BITS  = 114
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [KEY_BITS-1:0]   key_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  ks_bit_o,
  output logic                  ks_valid_o,
  output logic                  ks_dir_o
);
  logic       rst_meta_n, rst_sync_n;
  phase_t     phase;
  logic       clr, inject, vote_on, emit, emit_dir, emit_last;
  logic [KEY_BITS-1:0]   key_q, key_d;
  logic [FRAME_BITS-1:0] frm_q, frm_d;
  logic       din;
  logic [2:0] ctl_bits, step_en;
  logic [A_W-1:0] ra;
  logic [B_W-1:0] rb;
  logic [C_W-1:0] rc;
  logic       valid_q, dir_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  mvk_seq #(
    .KEY_BITS(KEY_BITS), .FRAME_BITS(FRAME_BITS),
    .MIX_STEPS(MIX_STEPS), .HALF_BITS(HALF_BITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start(start_i), .phase(phase),
    .clr(clr), .inject(inject), .vote_on(vote_on), .emit(emit),
    .emit_dir(emit_dir), .emit_last(emit_last)
  );

  always_comb begin
    key_d = key_q;
    frm_d = frm_q;
    if (clr) begin
      key_d = key_i;
      frm_d = frame_i;
    end else begin
      if (phase == PH_KEY)   key_d = key_q >> 1;
      if (phase == PH_FRAME) frm_d = frm_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      key_q <= '0;
      frm_q <= '0;
    end else begin
      key_q <= key_d;
      frm_q <= frm_d;
    end
  end

  assign din = (phase == PH_KEY) ? key_q[0] : (phase == PH_FRAME) ? frm_q[0] : 1'b0;

  assign ctl_bits = {rc[C_CLK], rb[B_CLK], ra[A_CLK]};

  mvk_vote u_vote (
    .clk(clk), .rst_n(rst_sync_n), .force_all(inject), .vote_on(vote_on),
    .ctl_bits(ctl_bits), .step_en(step_en)
  );

  mvk_lfsr #(.W(A_W), .TAPS(A_TAPS)) u_ra (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .en(step_en[0]), .din(din), .q(ra));
  mvk_lfsr #(.W(B_W), .TAPS(B_TAPS)) u_rb (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .en(step_en[1]), .din(din), .q(rb));
  mvk_lfsr #(.W(C_W), .TAPS(C_TAPS)) u_rc (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .en(step_en[2]), .din(din), .q(rc));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= emit;
      dir_q   <= emit_dir;
      done_q  <= emit_last;
    end
  end

  assign busy_o     = (phase != PH_IDLE);
  assign done_o     = done_q;
  assign ks_valid_o = valid_q;
  assign ks_dir_o   = dir_q;
  assign ks_bit_o   = ra[A_W-1] ^ rb[B_W-1] ^ rc[C_W-1];

  // R9: direction flag only accompanies a valid bit
  a_r9_dir_with_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ks_dir_o |-> ks_valid_o);
  // R11: done lasts one cycle and arrives with a valid bit while idle
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> (ks_valid_o && !busy_o));
  // R7: no output while mixing
  a_r7_silent_mix: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_MIX) |=> !ks_valid_o);
endmodule

// File: tb/test_mvote_keystream.sv
`timescale 1ns/1ps
module test_mvote_keystream;
  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [63:0] key_i;
  logic [21:0] frame_i;
  logic busy_o, done_o, ks_bit_o, ks_valid_o, ks_dir_o;
  int   errors = 0;
  int   checks = 0;
  bit   wd_fired = 1'b0;

  always #2.5 clk = ~clk;

  mvote_keystream i_mvote_keystream (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i), .frame_i(frame_i),
    .busy_o(busy_o), .done_o(done_o), .ks_bit_o(ks_bit_o),
    .ks_valid_o(ks_valid_o), .ks_dir_o(ks_dir_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Arithmetic model of R2..R8: bit i of the result is output bit i
  function automatic logic [227:0] model(input logic [63:0] k, input logic [21:0] f);
    logic [18:0] a; logic [21:0] b; logic [22:0] c;
    logic fa, fb, fc, x, m;
    logic [227:0] o;
    int s;
    a = '0; b = '0; c = '0; o = '0;
    for (int i = 0; i < 414; i++) begin
      fa = a[18] ^ a[17] ^ a[16] ^ a[13];
      fb = b[21] ^ b[20];
      fc = c[22] ^ c[21] ^ c[20] ^ c[7];
      if (i < 86) begin
        x = (i < 64) ? k[i] : f[i-64];
        a = {a[17:0], fa ^ x};
        b = {b[20:0], fb ^ x};
        c = {c[21:0], fc ^ x};
      end else begin
        s = int'(a[8]) + int'(b[10]) + int'(c[10]);
        m = (s >= 2);
        if (a[8] == m)  a = {a[17:0], fa};
        if (b[10] == m) b = {b[20:0], fb};
        if (c[10] == m) c = {c[21:0], fc};
        if (i >= 186) o[i-186] = a[18] ^ b[21] ^ c[22];
      end
    end
    return o;
  endfunction

  // one complete run; if stray is set, extra start pulses with another key arrive mid-run
  task automatic run_one(input logic [63:0] k, input logic [21:0] f, input bit stray);
    logic [227:0] exp_ks, got;
    int idx;
    int first_n;
    int done_n;
    exp_ks = model(k, f);
    got = '0; idx = 0; first_n = -1; done_n = -1;
    @(negedge clk);
    key_i = k; frame_i = f; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    key_i = ~k; frame_i = ~f;
    for (int n = 1; n <= 416; n++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (ks_valid_o) begin
        if (first_n < 0) first_n = n;
        if (idx < 228) begin
          got[idx] = ks_bit_o;
          if (ks_dir_o != (idx >= 114)) chk(1'b0, "R9 dir", int'(ks_dir_o), int'(idx >= 114));
        end
        idx++;
      end else if (ks_dir_o) chk(1'b0, "R9 dir idle", 1, 0);
      if (done_o) begin
        if (done_n >= 0) chk(1'b0, "R11 second done", n, done_n);
        done_n = n;
      end
      if (n == 100) chk(busy_o == 1'b1, "R12 busy mid", int'(busy_o), 1);
      if (n == 180) chk(ks_valid_o == 1'b0, "R7 silent mix", int'(ks_valid_o), 0);
      if (n == 413) chk(busy_o == 1'b1, "R12 busy end", int'(busy_o), 1);
      if (n == 414) chk(busy_o == 1'b0, "R11 idle at last bit", int'(busy_o), 0);
      if (stray && (n == 30 || n == 150 || n == 300)) start_i = 1'b1;
    end
    chk(first_n == 187, "R12 first bit", first_n, 187);
    chk(done_n == 414, "R11 done time", done_n, 414);
    chk(idx == 228, "R9 count", idx, 228);
    for (int j = 0; j < 228; j++)
      chk(got[j] == exp_ks[j], stray ? "R10 stream" : "R8 stream", int'(got[j]), int'(exp_ks[j]));
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; key_i = '0; frame_i = '0;
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!busy_o && !done_o && !ks_valid_o && !ks_dir_o, "R1 reset",
            int'({busy_o, done_o, ks_valid_o, ks_dir_o}), 0);
        // all-zero state yields all-zero stream (R4 clear)
        run_one(64'h0, 22'h0, 1'b0);
        // R5 each key bit position alone
        for (int p = 0; p < 64; p++) run_one(64'h1 << p, 22'h0, 1'b0);
        // R6 each frame bit position alone
        for (int p = 0; p < 22; p++) run_one(64'h0, 22'h1 << p, 1'b0);
        // R2 R3 dense patterns
        run_one(64'hFFFF_FFFF_FFFF_FFFF, 22'h3FFFFF, 1'b0);
        run_one(64'h0123_4567_89AB_CDEF, 22'h134, 1'b0);
        run_one(64'hA5C3_1E7F_0B92_D468, 22'h2C5A1, 1'b0);
        // R10 stray starts during key, mix and output phases
        run_one(64'h0123_4567_89AB_CDEF, 22'h134, 1'b1);
        run_one(64'h8000_0000_0000_0001, 22'h200001, 1'b1);
      end
      begin
        repeat (150000) @(posedge clk);
        wd_fired = 1'b1;
      end
    join_any
    disable fork;
    if (wd_fired) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule